// File: doc/BRIEF.md
# Bus Master Latency Timer

This block bounds how long a bus master may keep a burst running once the arbiter has withdrawn its grant. Software programs an 8-bit latency value, counted in bus clocks, through a simple register port. When the master starts a transaction by asserting its frame signal, the block loads a down-counter from that value. While the count runs, the grant has no effect. Once the count reaches zero, the block raises a terminate request to the master's transaction sequencer as soon as the grant is low.

If the master ends the transaction before the count runs out, the timer leaves no trace. Each new frame assertion starts from the value programmed at that moment. The terminate request is sticky: it holds until the master releases frame. The arbiter, the address and data phases and the rest of the master sequencer lie outside this block.

Top module: `bus_latency_timer`

## Requirements
- R1: The latency register resets to 00h. A write (`latWrEn` high at a clock edge) stores all 8 bits of `latWrData`, and `latRdData` shows the stored value from the following cycle on.
- R2: When `frameAct` is sampled high at an edge, with no transaction already being timed, the counter loads the register value L (L > 0). The count is expired from the L-th following edge onward. `termReq` can assert no earlier than that.
- R3: While `grantIn` is high, `termReq` does not newly assert, even when the count has expired.
- R4: If `frameAct` falls before the count expires, `termReq` stays low for that transaction, whatever `grantIn` does.
- R5: A register value of 0 makes the count expire at the frame-start edge itself. `termReq` then follows only the grant, from the next cycle.
- R6: Once asserted, `termReq` stays high while `frameAct` stays high, even if `grantIn` returns.
- R7: The counter stops at zero and does not wrap. An expired transaction held under grant for much longer than L still terminates when the grant is removed.
- R8: A register write during a transaction leaves that transaction's count unchanged. The new value is used from the next frame assertion.
- R9: `termReq` is low in every cycle in which `frameAct` is low. A frame low for one sampled edge ends the transaction, and the next high sample starts a new one.

Port list order for the table below follows the module declaration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| latWrEn | input | 1 | Latency register write strobe |
| latWrData | input | 8 | Latency register write data |
| latRdData | output | 8 | Latency register read data |
| frameAct | input | 1 | High while the master drives its frame signal active |
| grantIn | input | 1 | Arbiter grant to this master, high when granted |
| termReq | output | 1 | Request to the master sequencer to terminate the transaction |

## Verification
The hardest situation to reach is a register write that lands in the middle of a timed transaction. The stimulus has to prove that the running count ignores the new value and that the next frame picks it up. The bench writes a new value a few cycles after frame start and drops the grant early, so a count taken from the wrong value shows up as a terminate request in the wrong cycle. It then runs a fresh frame under the new value. Saturation is reached by holding frame and grant far beyond the programmed count before releasing the grant.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef struct packed {
    logic load;  // take the register value into the counter
    logic dec;   // step the counter down by one
  } cntCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_EXPIRED = 2'd2,
    ST_TERM    = 2'd3
  } latState_t;
endpackage

// File: rtl/lat_datapath.sv
module lat_datapath
  import lat_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  cntCtl_t          ctl,
  output logic [REG_W-1:0] latValue,
  output logic             latIsZero,
  output logic             cntIsOne
);
  localparam logic [REG_W-1:0] ZERO_V = '0;
  localparam logic [REG_W-1:0] ONE_V  = {{(REG_W-1){1'b0}}, 1'b1};

  logic [REG_W-1:0] latReg;
  logic [REG_W-1:0] cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) latReg <= ZERO_V;
    else if (wrEn) latReg <= wrData;
  end

  // Load takes the register value held before any same-edge write.
  always_ff @(posedge clk) begin
    if (!rstN) cntReg <= ZERO_V;
    else if (ctl.load) cntReg <= latReg;
    else if (ctl.dec && cntReg != ZERO_V) cntReg <= cntReg - ONE_V;
  end

  assign latValue  = latReg;
  assign latIsZero = (latReg == ZERO_V);
  assign cntIsOne  = (cntReg == ONE_V);
endmodule

// File: rtl/lat_control.sv
module lat_control
  import lat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameAct,
  input  logic      grantIn,
  input  logic      latIsZero,
  input  logic      cntIsOne,
  output cntCtl_t   ctl,
  output logic      termReq
);
  latState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (frameAct) begin
          ctl.load = 1'b1;
          stateNext = latIsZero ? ST_EXPIRED : ST_RUN;
        end
      end
      ST_RUN: begin
        if (!frameAct) stateNext = ST_IDLE;
        else begin
          ctl.dec = 1'b1;
          if (cntIsOne) stateNext = ST_EXPIRED;
        end
      end
      ST_EXPIRED: begin
        if (!frameAct) stateNext = ST_IDLE;
        else if (!grantIn) stateNext = ST_TERM;
      end
      ST_TERM: begin
        if (!frameAct) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign termReq = frameAct &&
                   ((state == ST_EXPIRED && !grantIn) || state == ST_TERM);
endmodule

// File: rtl/bus_latency_timer.sv
module bus_latency_timer
  import lat_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             latWrEn,
  input  logic [REG_W-1:0] latWrData,
  output logic [REG_W-1:0] latRdData,
  input  logic             frameAct,
  input  logic             grantIn,
  output logic             termReq
);
  cntCtl_t ctl;
  logic    latIsZero;
  logic    cntIsOne;

  lat_datapath #(.REG_W(REG_W)) i_datapath (
    .clk(clk), .rstN(rstN), .wrEn(latWrEn), .wrData(latWrData),
    .ctl(ctl), .latValue(latRdData), .latIsZero(latIsZero), .cntIsOne(cntIsOne)
  );

  lat_control i_control (
    .clk(clk), .rstN(rstN), .frameAct(frameAct), .grantIn(grantIn),
    .latIsZero(latIsZero), .cntIsOne(cntIsOne), .ctl(ctl), .termReq(termReq)
  );
endmodule

// File: rtl/lat_checker.sv
module lat_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             latWrEn,
  input logic [REG_W-1:0] latWrData,
  input logic [REG_W-1:0] latRdData,
  input logic             frameAct,
  input logic             grantIn,
  input logic             termReq
);
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rstN)
    latWrEn |=> latRdData == $past(latWrData));

  assert_grant_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (termReq && grantIn) |-> $past(termReq));

  assert_zero_expires_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameAct) && latRdData == '0) |=> (termReq || grantIn || !frameAct));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    termReq |=> (termReq || !frameAct));

  assert_no_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameAct |-> !termReq);
endmodule

bind bus_latency_timer lat_checker #(.REG_W(REG_W)) i_lat_checker (
  .clk(clk), .rstN(rstN), .latWrEn(latWrEn), .latWrData(latWrData),
  .latRdData(latRdData), .frameAct(frameAct), .grantIn(grantIn), .termReq(termReq)
);

// File: tb/test_bus_latency_timer.sv
module test_bus_latency_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       latWrEn = 1'b0;
  logic [7:0] latWrData = 8'h00;
  logic [7:0] latRdData;
  logic       frameAct = 1'b0;
  logic       grantIn = 1'b1;
  logic       termReq;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";

  // behavioural reference state
  int mLat = 0;
  int mRem = 0;
  bit mInTx = 0;
  bit mExpired = 0;
  bit mTerm = 0;

  always #10 clk = ~clk;

  bus_latency_timer i_bus_latency_timer (
    .clk(clk), .rstN(rstN), .latWrEn(latWrEn), .latWrData(latWrData),
    .latRdData(latRdData), .frameAct(frameAct), .grantIn(grantIn), .termReq(termReq)
  );

  task automatic modelEdge();
    int oldLat = mLat;
    if (!rstN) begin
      mLat = 0; mRem = 0; mInTx = 0; mExpired = 0; mTerm = 0;
      return;
    end
    if (!mInTx) begin
      if (frameAct) begin
        mInTx = 1; mRem = oldLat; mExpired = (oldLat == 0); mTerm = 0;
      end
    end else if (!frameAct) begin
      mInTx = 0; mExpired = 0; mTerm = 0;
    end else if (mExpired) begin
      if (!grantIn) mTerm = 1;
    end else begin
      mRem = mRem - 1;
      if (mRem == 0) mExpired = 1;
    end
    if (latWrEn) mLat = latWrData;
  endtask

  task automatic compare();
    bit expTerm = frameAct && (mTerm || (mExpired && !grantIn));
    nChecks++;
    if (termReq !== expTerm) begin
      nFails++;
      $display("FAIL %s termReq actual=%b expected=%b at %0t", curReq, termReq, expTerm, $time);
    end
    nChecks++;
    if (latRdData !== mLat[7:0]) begin
      nFails++;
      $display("FAIL %s latRdData actual=%02h expected=%02h at %0t", curReq, latRdData, mLat[7:0], $time);
    end
  endtask

  // Drive inputs (at negedge), pass one edge, compare at the next negedge.
  task automatic step(input bit f, input bit g, input bit we = 0, input logic [7:0] wd = 8'h00);
    frameAct = f; grantIn = g; latWrEn = we; latWrData = wd;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
  endtask

  task automatic repeatStep(input int n, input bit f, input bit g);
    for (int i = 0; i < n; i++) step(f, g);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(negedge clk);
    curReq = "R1";
    repeat (3) step(0, 1);
    rstN = 1'b1;
    step(0, 1);                      // R1 reset value 00h
    step(0, 1, 1, 8'h5A);
    step(0, 1, 1, 8'hFF);
    step(0, 1, 1, 8'h03);
    step(0, 1);

    curReq = "R3";                   // L=3, grant held long past expiry
    repeat (8) step(1, 1);
    curReq = "R7";                   // saturated counter, grant removed late
    repeat (2) step(1, 0);
    step(0, 1);

    curReq = "R2";                   // L=4, grant low from start
    step(0, 1, 1, 8'h04);
    repeatStep(7, 1, 0);
    step(0, 0);

    curReq = "R4";                   // L=6, frame dropped early
    step(0, 1, 1, 8'h06);
    repeatStep(4, 1, 0);
    repeatStep(3, 0, 0);
    step(0, 1);

    curReq = "R5";                   // L=0
    step(0, 1, 1, 8'h00);
    repeatStep(2, 1, 1);
    repeatStep(2, 1, 0);
    curReq = "R6";                   // grant returns, request must hold
    repeatStep(3, 1, 1);
    step(0, 1);

    curReq = "R8";                   // write mid transaction
    step(0, 1, 1, 8'h05);
    step(1, 0);
    step(1, 0, 1, 8'h01);
    repeatStep(6, 1, 0);
    step(0, 1);
    repeatStep(4, 1, 0);             // next frame uses L=1
    step(0, 1);

    curReq = "R9";                   // one-cycle gap restarts the count
    step(0, 1, 1, 8'h02);
    repeatStep(3, 1, 0);
    step(0, 0);
    repeatStep(4, 1, 0);
    repeatStep(2, 0, 0);
    repeatStep(2, 0, 1);

    finishRun();
  end
endmodule